// File: doc/BRIEF.md
# Two-Wire Bus Master Receiver with Status Codes

This block is a two-wire (I2C) bus master that runs the read side of a transfer one bus step at a time. Software drives it through a small command word: enable, start, stop and acknowledge-enable bits, plus a go bit. Writing one to go clears the event flag and launches the next step. When a step finishes, the hardware raises the flag and posts an 8-bit status code that names the bus event. While the flag is up, the block holds SCL low, so the bus waits for software.

The steps are:
- a START, which waits until the bus is free, or a repeated START;
- sending the address byte with its read bit, then sampling the slave's acknowledge;
- receiving data bytes, each answered with ACK or NACK as the acknowledge-enable bit chooses;
- a STOP.

SCL and SDA are open-drain. Each output means "pull this line low". The bit timing is four quarter periods, and each quarter lasts `clk_div + 1` clock cycles.

The address byte enters through a valid/ready port. `tx_ready` is high only while the engine is idle or parked with the flag up. A byte offered at any other time waits. Received bytes appear on `rx_data` together with the flag. They need no back-pressure, because the engine does nothing more until software clears the flag.

Top module: `i2c_mrx`

## Requirements
- R1: After reset the flag is 0, the status is 0xF8, both line drivers are released and `tx_ready` is 1.
- R2: With enable, start and go set and the bus free, the block issues a START (SDA falls while SCL is high). It then sets the flag, reports 0x08 and holds SCL low.
- R3: A go with no start or stop after status 0x08 or 0x10 sends the loaded byte MSB first. When the slave ACKs on the ninth clock, the block reports 0x40 and sets the flag.
- R4: If the ninth clock of the address byte finds SDA high (NACK), the block reports 0x48.
- R5: A go after 0x40 or 0x50 with acknowledge-enable 1 receives eight bits MSB first and drives ACK (SDA low) on the ninth clock. It then reports 0x50 and presents the byte on `rx_data`.
- R6: The same step with acknowledge-enable 0 leaves SDA released on the ninth clock (NACK) and reports 0x58.
- R7: Start with go while the block owns the bus produces a repeated START with no STOP in between, and reports 0x10.
- R8: Stop with go while the block owns the bus raises SDA while SCL is high. After that, `stop_pend` returns to 0, the flag stays 0, the status becomes 0xF8 and both lines are released.
- R9: A START requested while another master's START has marked the bus busy is held back, with no line driven, until a STOP is seen on the bus.
- R10: If SDA reads low while the block sends a 1 bit of the address, the block releases both lines, reports 0x38 and sets the flag.
- R11: Only a command write with go = 1 clears the flag. A command write with go = 0 leaves the flag, the status and the lines unchanged.
- R12: A command with go = 1 and enable = 0 clears the flag and releases both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div | input | DIV_W | Quarter bit period minus one, in clocks |
| cmd_wr | input | 1 | Command write strobe |
| cmd_en | input | 1 | Enable bit |
| cmd_start | input | 1 | Request START / repeated START |
| cmd_stop | input | 1 | Request STOP |
| cmd_ack | input | 1 | ACK (1) or NACK (0) for the next received byte |
| cmd_go | input | 1 | Write one: clear flag and launch a step |
| tx_valid | input | 1 | Address byte offered |
| tx_ready | output | 1 | Address byte accepted this cycle if valid |
| tx_data | input | 8 | Address byte (7-bit address and read bit in bit 0) |
| irq_flag | output | 1 | Step-complete flag |
| status | output | 8 | Status code of the last bus event |
| rx_data | output | 8 | Last received byte |
| stop_pend | output | 1 | STOP requested and not yet finished |
| scl_in | input | 1 | Sensed SCL line |
| sda_in | input | 1 | Sensed SDA line |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The bench builds the block with `DIV_W = 4` and drives `clk_div = 3`, so one bit takes 16 clocks and a full address-plus-two-byte read fits in a few hundred cycles. This short bit time leaves room for the slower paths within the run: the wait for a foreign STOP, the arbitration loss against a second bench driver on SDA, and the repeated START after an address NACK. A quarter period of four clocks also gives the bench slave, which reacts one clock after each SCL edge, time to settle SDA before the block samples it.

// File: rtl/i2c_mrx_pkg.sv
package i2c_mrx_pkg;
  localparam logic [7:0] ST_START  = 8'h08;
  localparam logic [7:0] ST_RSTART = 8'h10;
  localparam logic [7:0] ST_LOST   = 8'h38;
  localparam logic [7:0] ST_AACK   = 8'h40;
  localparam logic [7:0] ST_ANACK  = 8'h48;
  localparam logic [7:0] ST_DACK   = 8'h50;
  localparam logic [7:0] ST_DNACK  = 8'h58;
  localparam logic [7:0] ST_NONE   = 8'hF8;

  typedef enum logic [2:0] {
    E_IDLE, E_WAIT, E_START, E_TX, E_RX, E_STOP, E_HOLD
  } eng_state_t;
endpackage

// File: rtl/i2c_mrx_tick.sv
module i2c_mrx_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt >= div) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt >= div);
endmodule

// File: rtl/i2c_mrx_busmon.sv
module i2c_mrx_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic busy
);
  logic scl_q, sda_q;
  logic saw_start, saw_stop;

  assign saw_start = scl_q && scl_in && sda_q && !sda_in;
  assign saw_stop  = scl_q && scl_in && !sda_q && sda_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (saw_start) busy <= 1'b1;
      else if (saw_stop) busy <= 1'b0;
    end
  end

  // R9
  busy_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (saw_stop && !saw_start) |=> !busy);
endmodule

// File: rtl/i2c_mrx_engine.sv
module i2c_mrx_engine
  import i2c_mrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       bus_busy,
  input  logic       cmd_wr,
  input  logic       cmd_en,
  input  logic       cmd_start,
  input  logic       cmd_stop,
  input  logic       cmd_ack,
  input  logic       cmd_go,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  input  logic       sda_in,
  output logic       tx_ready,
  output logic       run,
  output logic       irq_flag,
  output logic [7:0] status,
  output logic [7:0] rx_data,
  output logic       stop_pend,
  output logic       scl_low,
  output logic       sda_low
);
  eng_state_t  state;
  logic [1:0]  q;
  logic [3:0]  bitn;
  logic [7:0]  shreg;
  logic [7:0]  dreg;
  logic        ack_en;
  logic        own;
  logic        rs;
  logic        samp;
  logic        launch;

  assign tx_ready  = (state == E_IDLE) || (state == E_HOLD);
  assign run       = (state == E_START) || (state == E_TX) ||
                     (state == E_RX) || (state == E_STOP);
  assign rx_data   = dreg;
  assign launch    = cmd_wr && cmd_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= E_IDLE;
      q         <= '0;
      bitn      <= '0;
      shreg     <= '0;
      dreg      <= '0;
      ack_en    <= 1'b0;
      own       <= 1'b0;
      rs        <= 1'b0;
      samp      <= 1'b0;
      irq_flag  <= 1'b0;
      status    <= ST_NONE;
      stop_pend <= 1'b0;
      scl_low   <= 1'b0;
      sda_low   <= 1'b0;
    end else begin
      if (tx_valid && tx_ready) dreg <= tx_data;
      if (cmd_wr) ack_en <= cmd_ack;
      unique case (state)
        E_IDLE, E_HOLD: begin
          if (launch) begin
            irq_flag <= 1'b0;
            q        <= '0;
            bitn     <= '0;
            if (!cmd_en) begin
              state     <= E_IDLE;
              own       <= 1'b0;
              scl_low   <= 1'b0;
              sda_low   <= 1'b0;
              stop_pend <= 1'b0;
            end else if (cmd_stop && own) begin
              stop_pend <= 1'b1;
              state     <= E_STOP;
            end else if (cmd_start) begin
              rs    <= own;
              state <= own ? E_START : E_WAIT;
            end else if (own && (status == ST_START || status == ST_RSTART)) begin
              shreg <= dreg;
              state <= E_TX;
            end else if (own && (status == ST_AACK || status == ST_DACK)) begin
              state <= E_RX;
            end
          end
        end
        E_WAIT: begin
          if (!bus_busy) begin
            q     <= '0;
            state <= E_START;
          end
        end
        E_START: begin
          if (tick) begin
            q <= q + 2'd1;
            unique case (q)
              2'd0: sda_low <= 1'b0;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b1;
              2'd3: begin
                scl_low  <= 1'b1;
                own      <= 1'b1;
                irq_flag <= 1'b1;
                status   <= rs ? ST_RSTART : ST_START;
                state    <= E_HOLD;
              end
            endcase
          end
        end
        E_TX: begin
          if (tick) begin
            q <= q + 2'd1;
            unique case (q)
              2'd0: sda_low <= (bitn == 4'd8) ? 1'b0 : !shreg[7];
              2'd1: scl_low <= 1'b0;
              2'd2: begin
                if (bitn == 4'd8) samp <= !sda_in;
                else if (shreg[7] && !sda_in) begin
                  scl_low  <= 1'b0;
                  sda_low  <= 1'b0;
                  own      <= 1'b0;
                  irq_flag <= 1'b1;
                  status   <= ST_LOST;
                  state    <= E_IDLE;
                end
              end
              2'd3: begin
                scl_low <= 1'b1;
                if (bitn == 4'd8) begin
                  status   <= samp ? ST_AACK : ST_ANACK;
                  irq_flag <= 1'b1;
                  state    <= E_HOLD;
                end else begin
                  shreg <= {shreg[6:0], 1'b0};
                  bitn  <= bitn + 4'd1;
                end
              end
            endcase
          end
        end
        E_RX: begin
          if (tick) begin
            q <= q + 2'd1;
            unique case (q)
              2'd0: sda_low <= (bitn == 4'd8) ? ack_en : 1'b0;
              2'd1: scl_low <= 1'b0;
              2'd2: if (bitn != 4'd8) shreg <= {shreg[6:0], sda_in};
              2'd3: begin
                scl_low <= 1'b1;
                if (bitn == 4'd8) begin
                  dreg     <= shreg;
                  status   <= ack_en ? ST_DACK : ST_DNACK;
                  irq_flag <= 1'b1;
                  state    <= E_HOLD;
                end else begin
                  bitn <= bitn + 4'd1;
                end
              end
            endcase
          end
        end
        E_STOP: begin
          if (tick) begin
            q <= q + 2'd1;
            unique case (q)
              2'd0: sda_low <= 1'b1;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b0;
              2'd3: begin
                stop_pend <= 1'b0;
                own       <= 1'b0;
                status    <= ST_NONE;
                state     <= E_IDLE;
              end
            endcase
          end
        end
        default: state <= E_IDLE;
      endcase
    end
  end

  // R2
  flag_holds_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && own) |-> scl_low);

  // R10
  lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && status == ST_LOST) |-> (!scl_low && !sda_low));

  // R9
  start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_low && !$past(sda_low) && !scl_low && !own) |-> !bus_busy);

  // R8
  stop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_pend) |-> !irq_flag);

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !launch) |=> irq_flag);
endmodule

// File: rtl/i2c_mrx.sv
module i2c_mrx #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             cmd_wr,
  input  logic             cmd_en,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cmd_ack,
  input  logic             cmd_go,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             irq_flag,
  output logic [7:0]       status,
  output logic [7:0]       rx_data,
  output logic             stop_pend,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe
);
  logic run, tick, bus_busy;

  i2c_mrx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .div(clk_div), .tick(tick)
  );

  i2c_mrx_busmon u_busmon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .busy(bus_busy)
  );

  i2c_mrx_engine u_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_busy(bus_busy),
    .cmd_wr(cmd_wr), .cmd_en(cmd_en), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_ack(cmd_ack), .cmd_go(cmd_go),
    .tx_valid(tx_valid), .tx_data(tx_data), .sda_in(sda_in),
    .tx_ready(tx_ready), .run(run), .irq_flag(irq_flag), .status(status),
    .rx_data(rx_data), .stop_pend(stop_pend),
    .scl_low(scl_oe), .sda_low(sda_oe)
  );
endmodule

// File: tb/test_i2c_mrx.sv
`timescale 1ns/1ps
module test_i2c_mrx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] clk_div = 4'd3;
  logic       cmd_wr = 0, cmd_en = 0, cmd_start = 0, cmd_stop = 0, cmd_ack = 0, cmd_go = 0;
  logic       tx_valid = 0;
  logic [7:0] tx_data = '0;
  logic       tx_ready, irq_flag, stop_pend, scl_oe, sda_oe;
  logic [7:0] status, rx_data;
  logic       rival_low = 1'b0;
  logic       s_sda_low;
  wire        scl_line = !scl_oe;
  wire        sda_line = !(sda_oe || s_sda_low || rival_low);

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = !clk;

  i2c_mrx #(.DIV_W(4)) i_i2c_mrx (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .cmd_wr(cmd_wr), .cmd_en(cmd_en),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_ack(cmd_ack), .cmd_go(cmd_go),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .irq_flag(irq_flag),
    .status(status), .rx_data(rx_data), .stop_pend(stop_pend),
    .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // bench slave model
  logic [6:0] slave_addr = 7'h50;
  logic [7:0] data_q [8];
  logic       p_scl, p_sda, s_first, s_match, s_mack;
  logic [1:0] s_phase;
  logic [3:0] s_bit;
  logic [7:0] s_sh, s_tx, addr_seen;
  logic [2:0] s_idx;
  int starts, stops;

  always @(posedge clk) begin
    p_scl <= scl_line;
    p_sda <= sda_line;
    if (!rst_n) begin
      s_phase <= 0; s_bit <= 0; s_sda_low <= 0; s_first <= 0; s_match <= 0;
      s_mack <= 0; s_sh <= 0; s_tx <= 0; addr_seen <= 0; s_idx <= 0;
      starts <= 0; stops <= 0; p_scl <= 1; p_sda <= 1;
    end else if (p_scl && scl_line && p_sda && !sda_line) begin
      starts <= starts + 1; s_phase <= 1; s_bit <= 0; s_first <= 1;
      s_sda_low <= 0; s_idx <= 0;
    end else if (p_scl && scl_line && !p_sda && sda_line) begin
      stops <= stops + 1; s_phase <= 0; s_sda_low <= 0;
    end else if (!p_scl && scl_line) begin
      if (s_phase == 1 && s_bit < 8) s_sh <= {s_sh[6:0], sda_line};
      if (s_phase == 2 && s_bit == 8) s_mack <= !sda_line;
    end else if (p_scl && !scl_line) begin
      if (s_first) s_first <= 0;
      else if (s_phase == 1) begin
        if (s_bit == 7) begin
          s_bit <= 8; addr_seen <= s_sh;
          s_match <= (s_sh[7:1] == slave_addr) && s_sh[0];
          s_sda_low <= (s_sh[7:1] == slave_addr) && s_sh[0];
        end else if (s_bit == 8) begin
          s_bit <= 0;
          if (s_match) begin
            s_phase <= 2; s_tx <= data_q[s_idx]; s_sda_low <= !data_q[s_idx][7];
          end else begin
            s_phase <= 0; s_sda_low <= 0;
          end
        end else s_bit <= s_bit + 1;
      end else if (s_phase == 2) begin
        if (s_bit < 7) begin
          s_bit <= s_bit + 1; s_sda_low <= !s_tx[6 - s_bit];
        end else if (s_bit == 7) begin
          s_bit <= 8; s_sda_low <= 0;
        end else begin
          s_bit <= 0; s_idx <= s_idx + 3'd1;
          if (s_mack) begin
            s_tx <= data_q[s_idx + 3'd1]; s_sda_low <= !data_q[s_idx + 3'd1][7];
          end else begin
            s_phase <= 0; s_sda_low <= 0;
          end
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic en, input logic sta, input logic sto, input logic ack, input logic go);
    @(negedge clk);
    cmd_wr = 1; cmd_en = en; cmd_start = sta; cmd_stop = sto; cmd_ack = ack; cmd_go = go;
    @(negedge clk);
    cmd_wr = 0; cmd_go = 0;
  endtask

  task automatic load(input logic [7:0] d);
    @(negedge clk);
    tx_valid = 1; tx_data = d;
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic wait_flag(input string req);
    int n = 0;
    while (!irq_flag && n < 4000) begin @(negedge clk); n++; end
    if (!irq_flag) check(req, 0, 1);
  endtask

  task automatic wait_stop_done(input string req);
    int n = 0;
    while (stop_pend && n < 4000) begin @(negedge clk); n++; end
    check(req, stop_pend, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 flag", irq_flag, 0);
    check("R1 status", status, 8'hF8);
    check("R1 lines", {scl_oe, sda_oe}, 0);
    check("R1 ready", tx_ready, 1);
  endtask

  task automatic t_read_two;
    int st0;
    slave_addr = 7'h50; data_q[0] = 8'hA5; data_q[1] = 8'h3C;
    cmd(1, 1, 0, 0, 1);
    wait_flag("R2");
    check("R2 status", status, 8'h08);
    check("R2 scl held", scl_oe, 1);
    st0 = starts;
    cmd(1, 0, 0, 0, 0);
    repeat (60) @(negedge clk);
    check("R11 flag kept", irq_flag, 1);
    check("R11 status kept", status, 8'h08);
    check("R11 no bus event", starts, st0);
    load(8'hA1);
    cmd(1, 0, 0, 0, 1);
    wait_flag("R3");
    check("R3 status", status, 8'h40);
    check("R3 address on bus", addr_seen, 8'hA1);
    cmd(1, 0, 0, 1, 1);
    wait_flag("R5");
    check("R5 status", status, 8'h50);
    check("R5 data", rx_data, 8'hA5);
    check("R5 ack seen", s_mack, 1);
    cmd(1, 0, 0, 0, 1);
    wait_flag("R6");
    check("R6 status", status, 8'h58);
    check("R6 data", rx_data, 8'h3C);
    check("R6 nack seen", s_mack, 0);
    st0 = stops;
    cmd(1, 0, 1, 0, 1);
    check("R8 pending", stop_pend, 1);
    wait_stop_done("R8 stop done");
    check("R8 no flag", irq_flag, 0);
    check("R8 status", status, 8'hF8);
    check("R8 stop on bus", stops, st0 + 1);
    check("R8 lines", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_nack_rstart;
    int sp, st;
    slave_addr = 7'h50; data_q[0] = 8'h69;
    cmd(1, 1, 0, 0, 1);
    wait_flag("R2 second");
    load(8'h77);
    cmd(1, 0, 0, 0, 1);
    wait_flag("R4");
    check("R4 status", status, 8'h48);
    sp = stops; st = starts;
    cmd(1, 1, 0, 0, 1);
    wait_flag("R7");
    check("R7 status", status, 8'h10);
    check("R7 no stop", stops, sp);
    check("R7 start seen", starts, st + 1);
    load(8'hA1);
    cmd(1, 0, 0, 0, 1);
    wait_flag("R3 after rstart");
    check("R3 status after rstart", status, 8'h40);
    cmd(1, 0, 0, 0, 1);
    wait_flag("R6 after rstart");
    check("R6 data after rstart", rx_data, 8'h69);
    cmd(1, 0, 1, 0, 1);
    wait_stop_done("R8 second stop");
  endtask

  task automatic t_arb;
    cmd(1, 1, 0, 0, 1);
    wait_flag("R10 start");
    rival_low = 1;
    load(8'hA1);
    cmd(1, 0, 0, 0, 1);
    wait_flag("R10");
    check("R10 status", status, 8'h38);
    check("R10 lines released", {scl_oe, sda_oe}, 0);
    repeat (8) @(negedge clk);
    rival_low = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_busy;
    rival_low = 1;
    repeat (6) @(negedge clk);
    cmd(1, 1, 0, 0, 1);
    repeat (200) @(negedge clk);
    check("R9 held flag", irq_flag, 0);
    check("R9 held lines", {scl_oe, sda_oe}, 0);
    rival_low = 0;
    wait_flag("R9 start after stop");
    check("R9 status", status, 8'h08);
    cmd(1, 0, 1, 0, 1);
    wait_stop_done("R9 cleanup");
  endtask

  task automatic t_disable;
    cmd(1, 1, 0, 0, 1);
    wait_flag("R12 start");
    cmd(0, 0, 0, 0, 1);
    @(negedge clk);
    check("R12 flag", irq_flag, 0);
    check("R12 lines", {scl_oe, sda_oe}, 0);
    rival_low = 1; repeat (4) @(negedge clk);
    rival_low = 0; repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_two();
    t_nack_rstart();
    t_arb();
    t_busy();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule